// File: doc/BRIEF.md
# Clock Divider Best-Match Search

This block picks, from a small table of available source clock frequencies, the entry that gives the output frequency closest to a requested serial clock once it is divided down by an integer. Software or a small controller loads up to `MAX_LEVELS` source frequencies through a write port and sets how many of them are valid. It then pulses `start` with a request. The engine checks the valid entries one after another. For each entry it derives the smallest integer divider that keeps the divided clock at or below the request. It keeps the entry with the least shortfall.

One sequential divider is used twice for each entry. The first pass forms the ceiling of source over request. The second pass forms the divided output. The search stops early when an entry divides down to exactly the request. A caller that cannot accept an approximate clock sets `exact_only`, and the search then fails unless an exact entry exists. Results stay on the outputs until the next accepted `start`. A one-cycle `done` pulse marks them fresh.

Top module: `clkdiv_match_search`

## Requirements
- R1: After reset `busy`, `done`, `ok`, `exact_hit`, `best_idx` and `best_freq` are all zero.
- R2: A write with `tbl_we` high stores `tbl_wdata` in table slot `tbl_waddr` at the clock edge. `num_levels` is sampled on an accepted `start`, and a count above `MAX_LEVELS` is treated as `MAX_LEVELS`.
- R3: For an entry of frequency f and a request r, the divider is ceil(f / r), the output is floor(f / divider), and that output never exceeds r.
- R4: The chosen entry is the one with the smallest error r - output. An entry replaces the current best only when its error is strictly smaller, so on a tie the lowest index wins.
- R5: The first entry with zero error ends the search at once and is reported with `ok`=1 and `exact_hit`=1. Entries after it are not examined, so `done` comes within a few divider passes of that entry.
- R6: With `exact_only`=1 and no zero-error entry among the valid levels, the search reports `ok`=0.
- R7: With `exact_only`=0 and no zero-error entry, the search reports `ok`=1, `exact_hit`=0 and the closest entry.
- R8: A search started with zero valid levels reports `ok`=0 one cycle after `start`.
- R9: A search started with a request of zero reports `ok`=0 one cycle after `start`.
- R10: Whenever `ok`=0 is reported, `best_idx`, `best_freq` and `exact_hit` read zero.
- R11: `done` is high for exactly one cycle per accepted search, and `busy` is low in that cycle. `busy` is high from the cycle after an accepted `start` until `done`. A `start` while `busy` is high is ignored.
- R12: A table entry of zero gives an output of zero, so its error equals the request. It can still be chosen as the best entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | IDX_W | Table slot to write |
| tbl_wdata | input | FREQ_W | Source frequency to store |
| num_levels | input | CNT_W | Count of valid table entries, sampled at start |
| start | input | 1 | Begin a search (ignored while busy) |
| req_freq | input | FREQ_W | Requested serial clock frequency |
| exact_only | input | 1 | Fail unless an exact match exists |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: results valid |
| ok | output | 1 | Search succeeded |
| exact_hit | output | 1 | Reported entry divides to exactly the request |
| best_idx | output | IDX_W | Index of the chosen entry |
| best_freq | output | FREQ_W | Source frequency of the chosen entry |

## Verification
Faults in the running best error or best index show up only when `done` fires. They appear as a wrong `best_idx` or `best_freq`, most clearly in tie tables and in tables where a later entry beats an earlier one. A wrong divider quotient or ceiling rounding moves the chosen entry, or makes the block miss an exact hit. A missed exact hit also stretches the search latency to a full table scan, which the bench measures. A stuck state machine or a lost divider completion leaves `busy` high, so no `done` arrives and the scoreboard stays non-empty.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_CEIL  = 2'd2,
        S_OUT   = 2'd3
    } srch_state_e;

endpackage

// File: rtl/clkdiv_freq_table.sv
module clkdiv_freq_table #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [DEPTH-1:0] slot_we;
    logic [W-1:0]     slot_d [DEPTH];
    logic [W-1:0]     slot_q [DEPTH];

    // per-slot write decode
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_we[g] = we && (waddr == AW'(g));
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = slot_we[i] ? wdata : slot_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
        end
    end

    assign rdata = (int'(raddr) < DEPTH) ? slot_q[raddr] : '0;

endmodule

// File: rtl/clkdiv_seq_divider.sv
module clkdiv_seq_divider #(
    parameter int W  = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         done
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dsor;
        logic          done;
    } div_ctx_t;

    div_ctx_t dv_d, dv_q;
    logic [W:0] shifted;
    logic [W:0] diff;

    always_comb begin
        dv_d      = dv_q;
        dv_d.done = 1'b0;
        shifted   = {dv_q.rem, dv_q.quo[W-1]};
        diff      = shifted - {1'b0, dv_q.dsor};
        if (start) begin
            dv_d.busy = 1'b1;
            dv_d.cnt  = CW'(W);
            dv_d.rem  = '0;
            dv_d.quo  = dividend;
            dv_d.dsor = divisor;
        end else if (dv_q.busy) begin
            // restoring step: one quotient bit per cycle
            if (!diff[W]) begin
                dv_d.rem = diff[W-1:0];
                dv_d.quo = {dv_q.quo[W-2:0], 1'b1};
            end else begin
                dv_d.rem = shifted[W-1:0];
                dv_d.quo = {dv_q.quo[W-2:0], 1'b0};
            end
            dv_d.cnt = dv_q.cnt - CW'(1);
            if (dv_q.cnt == CW'(1)) begin
                dv_d.busy = 1'b0;
                dv_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign quotient  = dv_q.quo;
    assign remainder = dv_q.rem;
    assign done      = dv_q.done;

    // R3: the caller never hands over a zero divisor
    a_r3_divisor_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> divisor != '0);

    // R3: a finished division leaves a remainder below the divisor
    a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> dv_q.rem < dv_q.dsor);

endmodule

// File: rtl/clkdiv_match_search.sv
module clkdiv_match_search
    import clkdiv_pkg::*;
#(
    parameter int FREQ_W     = 32,
    parameter int MAX_LEVELS = 32,
    localparam int IDX_W     = (MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1,
    localparam int CNT_W     = $clog2(MAX_LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_waddr,
    input  logic [FREQ_W-1:0] tbl_wdata,
    input  logic [CNT_W-1:0]  num_levels,
    input  logic              start,
    input  logic [FREQ_W-1:0] req_freq,
    input  logic              exact_only,
    output logic              busy,
    output logic              done,
    output logic              ok,
    output logic              exact_hit,
    output logic [IDX_W-1:0]  best_idx,
    output logic [FREQ_W-1:0] best_freq
);

    typedef struct packed {
        srch_state_e       st;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [FREQ_W-1:0] req;
        logic              xonly;
        logic [FREQ_W-1:0] best_err;
        logic [IDX_W-1:0]  best_idx;
        logic [FREQ_W-1:0] best_freq;
        logic              done;
        logic              ok;
        logic              exact;
        logic [IDX_W-1:0]  out_idx;
        logic [FREQ_W-1:0] out_freq;
    } srch_ctx_t;

    srch_ctx_t sr_d, sr_q;

    logic [FREQ_W-1:0] rd_freq;
    logic              div_start;
    logic [FREQ_W-1:0] div_dsor;
    logic [FREQ_W-1:0] div_quo;
    logic [FREQ_W-1:0] div_rem;
    logic              div_done;
    logic [FREQ_W-1:0] ceil_v;
    logic [FREQ_W-1:0] out_v;
    logic [FREQ_W-1:0] err_v;
    logic [CNT_W-1:0]  lv_v;
    logic              eval;

    clkdiv_freq_table #(.W(FREQ_W), .DEPTH(MAX_LEVELS)) i_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (tbl_wdata),
        .raddr (sr_q.idx),
        .rdata (rd_freq)
    );

    clkdiv_seq_divider #(.W(FREQ_W)) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (div_start),
        .dividend  (rd_freq),
        .divisor   (div_dsor),
        .quotient  (div_quo),
        .remainder (div_rem),
        .done      (div_done)
    );

    always_comb begin
        sr_d      = sr_q;
        sr_d.done = 1'b0;
        div_start = 1'b0;
        div_dsor  = sr_q.req;
        ceil_v    = div_quo + {{(FREQ_W-1){1'b0}}, (div_rem != '0)};
        out_v     = '0;
        err_v     = '0;
        eval      = 1'b0;
        lv_v      = (num_levels > CNT_W'(MAX_LEVELS)) ? CNT_W'(MAX_LEVELS) : num_levels;

        unique case (sr_q.st)
            S_IDLE: begin
                if (start) begin
                    sr_d.req       = req_freq;
                    sr_d.xonly     = exact_only;
                    sr_d.idx       = '0;
                    sr_d.last      = IDX_W'(lv_v - CNT_W'(1));
                    sr_d.best_err  = '1;
                    sr_d.best_idx  = '0;
                    sr_d.best_freq = '0;
                    if (req_freq == '0 || lv_v == '0) begin
                        sr_d.done     = 1'b1;
                        sr_d.ok       = 1'b0;
                        sr_d.exact    = 1'b0;
                        sr_d.out_idx  = '0;
                        sr_d.out_freq = '0;
                    end else begin
                        sr_d.st = S_ISSUE;
                    end
                end
            end
            S_ISSUE: begin
                div_start = 1'b1;
                sr_d.st   = S_CEIL;
            end
            S_CEIL: begin
                if (div_done) begin
                    if (ceil_v == '0) begin
                        eval = 1'b1;          // zero entry: output is zero
                    end else begin
                        div_start = 1'b1;
                        div_dsor  = ceil_v;
                        sr_d.st   = S_OUT;
                    end
                end
            end
            S_OUT: begin
                if (div_done) begin
                    eval  = 1'b1;
                    out_v = div_quo;
                end
            end
            default: sr_d.st = S_IDLE;
        endcase

        if (eval) begin
            err_v = sr_q.req - out_v;
            if (err_v < sr_q.best_err) begin
                sr_d.best_err  = err_v;
                sr_d.best_idx  = sr_q.idx;
                sr_d.best_freq = rd_freq;
            end
            if (err_v == '0) begin
                sr_d.st       = S_IDLE;
                sr_d.done     = 1'b1;
                sr_d.ok       = 1'b1;
                sr_d.exact    = 1'b1;
                sr_d.out_idx  = sr_q.idx;
                sr_d.out_freq = rd_freq;
            end else if (sr_q.idx == sr_q.last) begin
                sr_d.st    = S_IDLE;
                sr_d.done  = 1'b1;
                sr_d.exact = 1'b0;
                if (sr_q.xonly) begin
                    sr_d.ok       = 1'b0;
                    sr_d.out_idx  = '0;
                    sr_d.out_freq = '0;
                end else begin
                    sr_d.ok       = 1'b1;
                    sr_d.out_idx  = sr_d.best_idx;
                    sr_d.out_freq = sr_d.best_freq;
                end
            end else begin
                sr_d.idx = sr_q.idx + IDX_W'(1);
                sr_d.st  = S_ISSUE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign busy      = (sr_q.st != S_IDLE);
    assign done      = sr_q.done;
    assign ok        = sr_q.ok;
    assign exact_hit = sr_q.exact;
    assign best_idx  = sr_q.out_idx;
    assign best_freq = sr_q.out_freq;

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r10_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ok) |-> (best_idx == '0 && best_freq == '0 && !exact_hit));

    a_r6_exact_required: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok && sr_q.xonly) |-> exact_hit);

    a_r9_zero_request: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && req_freq == '0) |=> (done && !ok));

    a_r8_no_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && num_levels == '0) |=> (done && !ok));

    a_r3_no_exceed: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_q.st == S_OUT && div_done) |-> div_quo <= sr_q.req);

endmodule

// File: tb/test_clkdiv_match_search.sv
module test_clkdiv_match_search;

    localparam int CLK_PERIOD = 10;
    localparam int FW = 32;
    localparam int ML = 32;
    localparam int IW = 5;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tbl_we = 1'b0;
    logic [IW-1:0] tbl_waddr = '0;
    logic [FW-1:0] tbl_wdata = '0;
    logic [CW-1:0] num_levels = '0;
    logic          start = 1'b0;
    logic [FW-1:0] req_freq = '0;
    logic          exact_only = 1'b0;
    logic          busy, done, ok, exact_hit;
    logic [IW-1:0] best_idx;
    logic [FW-1:0] best_freq;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_match_search #(.FREQ_W(FW), .MAX_LEVELS(ML)) i_clkdiv_match_search (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
        .tbl_wdata(tbl_wdata), .num_levels(num_levels), .start(start),
        .req_freq(req_freq), .exact_only(exact_only), .busy(busy), .done(done),
        .ok(ok), .exact_hit(exact_hit), .best_idx(best_idx), .best_freq(best_freq)
    );

    typedef struct {
        logic          ok;
        logic          ex;
        logic [IW-1:0] idx;
        logic [FW-1:0] freq;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            n_run = 0;
    int            n_fail = 0;
    logic [FW-1:0] mirror [ML];
    logic          prev_done = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [FW-1:0] rq, input int lv, input logic xo,
                                   input string tag);
        exp_t e;
        longint unsigned best_err = 64'hFFFF_FFFF;
        longint unsigned f, dv, o, er;
        int bi = 0;
        longint unsigned bf = 0;
        int n = (lv > ML) ? ML : lv;
        e.tag = tag; e.ok = 0; e.ex = 0; e.idx = '0; e.freq = '0;
        if (rq == 0 || n == 0) return e;
        for (int i = 0; i < n; i++) begin
            f = longint'(mirror[i]);
            if (f == 0) o = 0;
            else begin
                dv = (f + longint'(rq) - 1) / longint'(rq);
                o  = f / dv;
            end
            er = longint'(rq) - o;
            if (er < best_err) begin best_err = er; bi = i; bf = f; end
            if (er == 0) begin
                e.ok = 1; e.ex = 1; e.idx = IW'(i); e.freq = FW'(f);
                return e;
            end
        end
        if (!xo) begin e.ok = 1; e.idx = IW'(bi); e.freq = FW'(bf); end
        return e;
    endfunction

    task automatic wr(input int a, input logic [FW-1:0] v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_waddr = IW'(a); tbl_wdata = v;
        mirror[a] = v;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic search(input logic [FW-1:0] rq, input int lv, input logic xo,
                          input string tag, output int lat);
        sb.push_back(model(rq, lv, xo, tag));
        @(negedge clk);
        req_freq = rq; num_levels = CW'(lv); exact_only = xo; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (sb.size() != 0) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // monitor: compares results as they appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) check("R11 done single cycle", 64'(done), 64'd0);
            prev_done = done;
            if (done) begin
                check("R11 busy low with done", 64'(busy), 64'd0);
                if (sb.size() == 0) begin
                    check("R11 unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " ok"},    64'(ok),        64'(e.ok));
                    check({e.tag, " exact"}, 64'(exact_hit), 64'(e.ex));
                    check({e.tag, " idx"},   64'(best_idx),  64'(e.idx));
                    check({e.tag, " freq"},  64'(best_freq), 64'(e.freq));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int lat;
        logic [FW-1:0] seed;
        for (int i = 0; i < ML; i++) mirror[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy",  64'(busy), 0);
        check("R1 done",  64'(done), 0);
        check("R1 ok",    64'(ok), 0);
        check("R1 exact", 64'(exact_hit), 0);
        check("R1 idx",   64'(best_idx), 0);
        check("R1 freq",  64'(best_freq), 0);

        // R2 R3 R5: exact entry at index 2
        wr(0, 100); wr(1, 250); wr(2, 300); wr(3, 400);
        search(150, 4, 1'b0, "R2 R3 R5 exact", lat);

        // R7: closest wins, no exact
        wr(2, 301);
        search(150, 4, 1'b0, "R7 closest", lat);
        // R6 R10: same table, exact required
        search(150, 4, 1'b1, "R6 R10 exact required", lat);

        // R4: tie, lower index wins (10 -> 5, 15 -> 5 for request 7)
        wr(0, 10); wr(1, 15);
        search(7, 2, 1'b0, "R4 tie", lat);
        // R4: later strictly better entry replaces
        wr(0, 9); wr(1, 18);
        search(7, 2, 1'b0, "R4 later better", lat);

        // R12: zero entry has error equal to request
        wr(0, 0); wr(1, 5);
        search(7, 2, 1'b0, "R12 zero then five", lat);
        search(7, 1, 1'b0, "R12 zero alone", lat);

        // R8 R9 R10: early failures
        search(7, 0, 1'b0, "R8 R10 no levels", lat);
        check("R8 latency", 64'(lat), 64'd2);
        search(0, 2, 1'b0, "R9 R10 zero request", lat);
        check("R9 latency", 64'(lat), 64'd2);

        // R3: extreme values
        wr(0, 32'hFFFF_FFFF);
        search(3, 1, 1'b1, "R3 max over three", lat);
        search(32'hFFFF_FFFF, 1, 1'b0, "R3 max request", lat);

        // R2 clamp and full table with pseudo-random entries
        seed = 32'h1234_5678;
        for (int i = 0; i < ML; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            wr(i, (seed >> 6) | 32'd1);
        end
        search(32'd1_000_003, 63, 1'b0, "R2 clamp full scan", lat);
        search(32'd777_777, 40, 1'b0, "R2 R7 random table", lat);

        // R5 early exit: exact at index 2 of a 32-level table
        wr(2, 32'd3_000_000);
        search(32'd1_500_000, 32, 1'b0, "R5 early exit", lat);
        check("R5 early exit latency bound", 64'(lat <= 3*72), 64'd1);

        // R11: start while busy is ignored
        wr(0, 100); wr(1, 250); wr(2, 300);
        sb.push_back(model(150, 3, 1'b0, "R11 restart ignored"));
        @(negedge clk);
        req_freq = 150; num_levels = 3; exact_only = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        check("R11 busy during search", 64'(busy), 64'd1);
        req_freq = 1; num_levels = 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; req_freq = 150;
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R11 no extra result", 64'(sb.size()), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule